// File: doc/BRIEF.md
# Steered Interrupt Controller

This block gathers up to 32 interrupt lines into one status word and drives two request pins towards a processor: a normal request and a critical request. Each line is either edge-captured or level-following, chosen by a per-line trigger bit. Each status bit is gated by an enable bit. A critical-select bit then routes it to one of the two request pins. Software reaches the state through a plain register port with a 4-bit offset, read and write strobes and a 32-bit data word. Writes take effect at the clock edge. Read data is combinational while the read strobe is high.

An optional vector unit turns the highest-priority pending critical line into an address. The address is a base from a configuration register plus a fixed stride of 512 bytes per table slot. One configuration bit sets the scan direction, so either end of the table has the highest priority. The input lines and the register port are plain signals with no handshake. Every request and vector value is a function of registered state only, so it settles on the clock after the input change or write that caused it.

Top module: `irq_steer_top`

## Requirements
- R1: Input line n lands in status bit (31 - n), so line 0 is the most significant status bit.
- R2: With the trigger bit at 1, a 0-to-1 change on the line sets its status bit. The bit stays set after the line falls, until software clears it.
- R3: With the trigger bit at 0, the status bit and an internal level bit take the line's new value whenever the line changes.
- R4: Writing offset 0 (status) clears every status bit written as 1, then ORs back the level bits that are currently active.
- R5: Writing offset 1 (set) ORs the written word into status.
- R6: Offset 6 reads status AND enable (offset 2). Writes to offset 6 and to offset 7 (vector) change nothing.
- R7: The normal request is high when status AND enable AND NOT critical-select (offset 3) is nonzero. The critical request is high when status AND enable AND critical-select is nonzero.
- R8: A write to offset 8 (vector config) stores the word with bit 1 forced to 0. The vector base is that value with bits 1:0 cleared.
- R9: With config bit 0 = 0, the vector (offset 7) is base + i*512, where i is the lowest set bit of the pending critical word.
- R10: With config bit 0 = 1, the vector is base + (31 - i)*512, where i is the highest set bit of the pending critical word.
- R11: With no critical source pending, the vector reads 0. Offsets 9 to 15 read 0.
- R12: Reset clears every register to 0. Polarity (offset 4) holds and returns whatever is written but does not change capture. Trigger is offset 5.
- R13: Built with HAS_VECTOR = 0, offsets 7 and 8 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Interrupt lines, line n at index n |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe, taken at the clock edge |
| reg_rd | input | 1 | Read strobe; read data is zero when low |
| reg_wdata | input | NUM_SRC | Write data |
| reg_rdata | output | NUM_SRC | Read data, combinational |
| irq_normal | output | 1 | Non-critical request |
| irq_crit | output | 1 | Critical request |

## Verification
The bench builds the controller twice with 32 lines and a 512-byte stride: once with HAS_VECTOR = 1 and once with HAS_VECTOR = 0, both on the same stimulus. With 32 lines, every line can be swept in level mode and then in edge mode, which proves the reversed bit mapping at every position. The same width lets the vector be checked for each of the 32 single-source cases in both scan directions, with the expected address computed from the bit index. The copy without the vector unit shows that its vector and config offsets stay at zero while the full copy has a live vector.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  typedef enum logic [3:0] {
    OFS_STAT  = 4'd0,
    OFS_SET   = 4'd1,
    OFS_EN    = 4'd2,
    OFS_CRIT  = 4'd3,
    OFS_POL   = 4'd4,
    OFS_TRIG  = 4'd5,
    OFS_MSTAT = 4'd6,
    OFS_VEC   = 4'd7,
    OFS_VCFG  = 4'd8
  } reg_ofs_e;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic [N-1:0] trig,
  input  logic         clr_we,
  input  logic         set_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] status
);
  logic [N-1:0] status_q, lvl_q, prev_q;
  logic [N-1:0] nxt, lvl_nxt, chg, rise, lvl_chg;

  always_comb begin
    chg     = src ^ prev_q;
    rise    = src & ~prev_q;
    lvl_chg = chg & ~trig;
    nxt     = status_q;
    if (clr_we) nxt = (nxt & ~wdata) | lvl_q;
    if (set_we) nxt = nxt | wdata;
    nxt     = nxt | (rise & trig);
    nxt     = (nxt & ~lvl_chg) | (src & lvl_chg);
    lvl_nxt = (lvl_q & ~lvl_chg) | (src & lvl_chg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      lvl_q    <= '0;
      prev_q   <= '0;
    end else begin
      status_q <= nxt;
      lvl_q    <= lvl_nxt;
      prev_q   <= src;
    end
  end

  assign status = status_q;
endmodule

// File: rtl/irq_vecgen.sv
module irq_vecgen #(
  parameter int N           = 32,
  parameter int STRIDE_LOG2 = 9
) (
  input  logic [N-1:0] pending,
  input  logic         dir,
  input  logic [N-1:0] base,
  output logic [N-1:0] vec
);
  localparam int IDX_W = $clog2(N);

  logic [N-1:0]     ord;
  logic [IDX_W-1:0] idx;

  for (genvar g = 0; g < N; g++) begin : g_ord
    assign ord[g] = dir ? pending[N-1-g] : pending[g];
  end

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ord[i]) idx = IDX_W'(i);
    end
    vec = (|ord) ? (base + (N'(idx) << STRIDE_LOG2)) : '0;
  end
endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
  import irq_steer_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter bit HAS_VECTOR  = 1'b1,
  parameter int STRIDE_LOG2 = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [3:0]         reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  output logic               irq_normal,
  output logic               irq_crit
);
  localparam logic [NUM_SRC-1:0] CFG_KEEP  = ~(NUM_SRC'(2));
  localparam logic [NUM_SRC-1:0] BASE_KEEP = ~(NUM_SRC'(3));

  logic [NUM_SRC-1:0] src_w, status_w, vec_w;
  logic [NUM_SRC-1:0] en_q, cr_q, pol_q, trig_q, vcfg_q;
  logic [NUM_SRC-1:0] live_w;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_map
    assign src_w[NUM_SRC-1-g] = irq_in[g];
  end

  irq_capture #(.N(NUM_SRC)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .src    (src_w),
    .trig   (trig_q),
    .clr_we (reg_wr && reg_addr == OFS_STAT),
    .set_we (reg_wr && reg_addr == OFS_SET),
    .wdata  (reg_wdata),
    .status (status_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      cr_q   <= '0;
      pol_q  <= '0;
      trig_q <= '0;
      vcfg_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_EN:   en_q   <= reg_wdata;
        OFS_CRIT: cr_q   <= reg_wdata;
        OFS_POL:  pol_q  <= reg_wdata;
        OFS_TRIG: trig_q <= reg_wdata;
        OFS_VCFG: vcfg_q <= reg_wdata & CFG_KEEP;
        default:  ;
      endcase
    end
  end

  assign live_w     = status_w & en_q;
  assign irq_normal = |(live_w & ~cr_q);
  assign irq_crit   = |(live_w & cr_q);

  if (HAS_VECTOR) begin : g_vec
    irq_vecgen #(.N(NUM_SRC), .STRIDE_LOG2(STRIDE_LOG2)) u_vg (
      .pending (live_w & cr_q),
      .dir     (vcfg_q[0]),
      .base    (vcfg_q & BASE_KEEP),
      .vec     (vec_w)
    );
  end else begin : g_novec
    assign vec_w = '0;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        OFS_STAT, OFS_SET: reg_rdata = status_w;
        OFS_EN:            reg_rdata = en_q;
        OFS_CRIT:          reg_rdata = cr_q;
        OFS_POL:           reg_rdata = pol_q;
        OFS_TRIG:          reg_rdata = trig_q;
        OFS_MSTAT:         reg_rdata = live_w;
        OFS_VEC:           reg_rdata = HAS_VECTOR ? vec_w : '0;
        OFS_VCFG:          reg_rdata = HAS_VECTOR ? vcfg_q : '0;
        default:           reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk #(
  parameter int N      = 32,
  parameter bit VEC_ON = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] irq_in,
  input logic [3:0]   reg_addr,
  input logic         reg_wr,
  input logic [N-1:0] reg_wdata,
  input logic         irq_crit,
  input logic [N-1:0] status,
  input logic [N-1:0] trig,
  input logic [N-1:0] vcfg,
  input logic [N-1:0] vec
);
  logic [N-1:0] seen_in;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_in <= '0;
    else        seen_in <= irq_in;
  end

  AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd1 && irq_in == seen_in)
      |=> ((status & $past(reg_wdata)) == $past(reg_wdata))); // R5

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> (($past(status & trig) & ~status) == '0)); // R2

  AST_CFG_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd8)
      |=> (vcfg == ($past(reg_wdata) & ~(N'(2))))); // R8

  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_crit |-> (vec == '0)); // R11

  AST_VEC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (VEC_ON && irq_crit) |-> (vec[8:0] == (vcfg[8:0] & 9'h1FC))); // R9
endmodule

bind irq_steer_top irq_steer_chk #(.N(NUM_SRC), .VEC_ON(HAS_VECTOR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_in    (irq_in),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .irq_crit  (irq_crit),
  .status    (status_w),
  .trig      (trig_q),
  .vcfg      (vcfg_q),
  .vec       (vec_w)
);

// File: tb/irq_steer_top_tb.sv
module irq_steer_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata, rdata_nv;
  logic        irq_normal, irq_crit, nv_normal, nv_crit;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  irq_steer_top #(.NUM_SRC(32), .HAS_VECTOR(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(rdata), .irq_normal(irq_normal), .irq_crit(irq_crit));

  irq_steer_top #(.NUM_SRC(32), .HAS_VECTOR(1'b0)) u_novec (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_nv), .irq_normal(nv_normal), .irq_crit(nv_crit));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = rdata;
    reg_rd = 1'b0;
  endtask

  task automatic rd_nv(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = rdata_nv;
    reg_rd = 1'b0;
  endtask

  task automatic drive(input logic [31:0] x);
    @(negedge clk);
    irq_in = x;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v); check("R12 reset reg", v, 32'h0);
    end
    check("R12 reset outputs", {30'h0, irq_normal, irq_crit}, 32'h0);

    // R1 R3 level sweep
    for (int n = 0; n < 32; n++) begin
      drive(32'h1 << n);
      rd(4'd0, v); check("R1 R3 level high", v, 32'h8000_0000 >> n);
      drive(32'h0);
      rd(4'd0, v); check("R3 level low", v, 32'h0);
    end

    // R4 R5 R6 R12
    drive(32'h1);
    wr(4'd1, 32'h0000_00FF);
    rd(4'd0, v); check("R5 set ors", v, 32'h8000_00FF);
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd4, v); check("R12 polarity readback", v, 32'hFFFF_FFFF);
    rd(4'd0, v); check("R12 polarity no effect", v, 32'h8000_00FF);
    wr(4'd2, 32'h8000_00F0);
    rd(4'd6, v); check("R6 masked status", v, 32'h8000_00F0);
    wr(4'd6, 32'h0); wr(4'd7, 32'h1234_5678);
    rd(4'd6, v); check("R6 mstat write ignored", v, 32'h8000_00F0);
    rd(4'd2, v); check("R6 enable untouched", v, 32'h8000_00F0);
    rd(4'd7, v); check("R6 vector write ignored", v, 32'h0);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, v); check("R4 clear keeps level", v, 32'h8000_0000);
    drive(32'h0);
    rd(4'd0, v); check("R4 level drop", v, 32'h0);

    // R7 steering
    wr(4'd2, 32'h0000_000F); wr(4'd3, 32'h0000_0003);
    wr(4'd1, 32'h0000_0001);
    check("R7 crit only", {30'h0, irq_normal, irq_crit}, 32'h1);
    wr(4'd1, 32'h0000_0004);
    check("R7 both", {30'h0, irq_normal, irq_crit}, 32'h3);
    wr(4'd2, 32'h0);
    check("R7 disabled", {30'h0, irq_normal, irq_crit}, 32'h0);
    wr(4'd0, 32'hFFFF_FFFF);

    // R2 edge sweep
    wr(4'd5, 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) begin
      drive(32'h1 << n);
      drive(32'h0);
      rd(4'd0, v); check("R2 edge held", v, 32'h8000_0000 >> n);
      wr(4'd0, 32'hFFFF_FFFF);
      rd(4'd0, v); check("R2 edge cleared", v, 32'h0);
    end

    // R8 R9 R10 R11 vector
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd8, v); check("R8 cfg bit1", v, 32'hFFFF_FFFD);
    rd(4'd7, v); check("R11 vector idle", v, 32'h0);
    wr(4'd2, 32'hFFFF_FFFF); wr(4'd3, 32'hFFFF_FFFF);
    wr(4'd8, 32'h0004_0000);
    for (int b = 0; b < 32; b++) begin
      wr(4'd1, 32'h1 << b);
      rd(4'd7, v); check("R9 ascending", v, 32'h0004_0000 + 32'(b) * 512);
      check("R7 crit raised", {30'h0, irq_normal, irq_crit}, 32'h1);
      wr(4'd0, 32'hFFFF_FFFF);
    end
    wr(4'd8, 32'h0004_0003);
    rd(4'd8, v); check("R8 cfg store", v, 32'h0004_0001);
    for (int b = 0; b < 32; b++) begin
      wr(4'd1, 32'h1 << b);
      rd(4'd7, v); check("R10 descending", v, 32'h0004_0000 + 32'(31 - b) * 512);
      wr(4'd0, 32'hFFFF_FFFF);
    end
    wr(4'd1, 32'h0010_0008);
    rd(4'd7, v); check("R10 priority high end", v, 32'h0004_0000 + 11 * 512);
    rd_nv(4'd7, v); check("R13 no vector", v, 32'h0);
    rd_nv(4'd8, v); check("R13 no config", v, 32'h0);
    wr(4'd8, 32'h0004_0000);
    rd(4'd7, v); check("R9 priority low end", v, 32'h0004_0000 + 3 * 512);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd7, v); check("R11 vector cleared", v, 32'h0);
    for (int a = 9; a < 16; a++) begin
      rd(4'(a), v); check("R11 undefined offset", v, 32'h0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule